// File: doc/BRIEF.md
# Local Countdown Timer with Divider

This block is a 32-bit down-counter that turns a programmable timeout into a tagged interrupt request. Software programs three values through a narrow write port: a start value, a clock divider setting and a timer entry. The timer entry holds the interrupt vector, a mask flag and a repeat flag. A read port returns any of these values, and it can also return the live count.

Writing the start value restarts both the counter and the divider. In one-shot mode the counter runs down to zero and stops there. In periodic mode it reloads the start value and runs again. Each expiry whose entry is unmasked produces a one-cycle request that carries the entry's vector. An external INIT event masks the entry and clears the counter.

The sequencing is a small state machine with three states:
- `ST_IDLE`: not counting, count zero.
- `ST_RUN`: counting.
- `ST_DONE`: a one-shot run has expired and holds zero.

Its transitions are:
- LOAD: a nonzero start write moves any state to `ST_RUN`.
- ZERO: a zero start write moves any state to `ST_IDLE`.
- DEC: a tick with a nonzero count keeps `ST_RUN`.
- RELOAD: a periodic expiry keeps `ST_RUN`.
- FINISH: a one-shot expiry moves `ST_RUN` to `ST_DONE`.
- INIT: an INIT event moves any state to `ST_IDLE`.

Top module: `local_count_timer`

## Requirements
- R1: After reset:
  - the live count and the start value read 0;
  - the divider setting reads 0;
  - the timer entry reads 0x0001_0000 (masked, vector 0, one-shot);
  - `irq_valid` is low.
- R2: A divider write keeps only bits 0, 1 and 3 of the data (AND with 0xB). The stored value reads back with `rd_sel` = 1.
- R3: The divider code is {cfg[3], cfg[1:0]} and the shift is (code + 1) mod 8.
  - The counter advances once every 2^shift clocks, counted from the start-value write.
  - Code 7 divides by 1 and code 0 divides by 2.
- R4: `wr_sel` and `rd_sel` use these codes: 0 = start value, 1 = divider setting, 2 = timer entry, 3 = live count (read only). The timer entry layout is:
  - vector in bits 7:0;
  - mask in bit 16;
  - periodic mode in bit 17;
  - all other bits are dropped on write and read as 0.
- R5: After a nonzero start write of N at edge E0:
  - the live count reads N from the next cycle;
  - the count drops by one on each tick;
  - at tick k it reads N - k.
- R6: In one-shot mode, expiry happens on the tick after the count reached 0, at edge E0 + (N+1)·2^shift. The count then stays 0, and only one request is raised per start write.
- R7: In periodic mode, each expiry reloads N and raises a request every (N+1) ticks. The live count reads N - (ticks mod (N+1)).
- R8: A request is `irq_valid` high for one cycle, starting the cycle after the expiry edge. `irq_vector` equals the entry vector held at expiry. A masked entry raises nothing, but the count still runs.
- R9: A start value of 0 stops counting, raises no request and leaves the count at 0 in either mode. This includes stopping a running periodic timer.
- R10: A timer-entry write restarts neither the count nor the divider. The mask, mode and vector it sets apply at the next expiry.
- R11: An INIT event forces the entry to 0x0001_0000 and clears the start value and the live count. It stops counting with no request, and it takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_evt | input | 1 | INIT event, one-cycle pulse |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write register select |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read register select |
| rd_data | output | 32 | Read data, combinational |
| irq_valid | output | 1 | Interrupt request pulse |
| irq_vector | output | 8 | Vector of the request |

## Verification
The assertions assume that INIT is a synchronous pulse, and that the write strobe and selects are steady around the clock edge. They also assume that no periodic start value of 0 is expected to fire, so back-to-back requests are never legitimate. The bench drives every input on the falling edge, one write per cycle. It uses only periodic start values of 1 or more, so the one-cycle pulse property and the count-never-rises property stay valid.

// File: rtl/lct_pkg.sv
`timescale 1ns/1ps
package lct_pkg;

    localparam int unsigned VEC_W     = 8;
    localparam int unsigned SHIFT_W   = 3;
    localparam int unsigned CFG_W     = 4;
    localparam int unsigned MASK_POS  = 16;
    localparam int unsigned MODE_POS  = 17;

    localparam logic [1:0] SEL_START = 2'd0;
    localparam logic [1:0] SEL_DIV   = 2'd1;
    localparam logic [1:0] SEL_ENTRY = 2'd2;
    localparam logic [1:0] SEL_LIVE  = 2'd3;

    localparam logic [CFG_W-1:0] DIV_KEEP = 4'b1011;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } tmr_state_e;

    typedef struct packed {
        logic             periodic;
        logic             masked;
        logic [VEC_W-1:0] vector;
    } entry_t;

    localparam entry_t ENTRY_RST = '{periodic: 1'b0, masked: 1'b1, vector: '0};

    // Folds bit 3 of the setting down next to bits 1:0, then adds one (mod 8).
    function automatic logic [SHIFT_W-1:0] div_shift(input logic [CFG_W-1:0] cfg);
        logic [SHIFT_W-1:0] code;
        code = {cfg[3], cfg[1:0]};
        return code + SHIFT_W'(1);
    endfunction

endpackage

// File: rtl/lct_regs.sv
`timescale 1ns/1ps
module lct_regs
    import lct_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_evt,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] start_val,
    output logic [CFG_W-1:0] div_cfg,
    output entry_t           entry,
    output logic             load
);

    logic wr_start, wr_div, wr_entry;

    always_comb begin
        wr_start = wr_en && (wr_sel == SEL_START);
        wr_div   = wr_en && (wr_sel == SEL_DIV);
        wr_entry = wr_en && (wr_sel == SEL_ENTRY);
        load     = wr_start && !init_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_val <= '0;
            div_cfg   <= '0;
            entry     <= ENTRY_RST;
        end else if (init_evt) begin
            start_val <= '0;
            entry     <= ENTRY_RST;
            if (wr_div) div_cfg <= wr_data[CFG_W-1:0] & DIV_KEEP;
        end else begin
            if (wr_start) start_val <= wr_data;
            if (wr_div)   div_cfg   <= wr_data[CFG_W-1:0] & DIV_KEEP;
            if (wr_entry) begin
                entry.vector   <= wr_data[VEC_W-1:0];
                entry.masked   <= wr_data[MASK_POS];
                entry.periodic <= wr_data[MODE_POS];
            end
        end
    end

endmodule

// File: rtl/lct_prescaler.sv
`timescale 1ns/1ps
module lct_prescaler
    import lct_pkg::*;
#(
    parameter int unsigned SH_W = SHIFT_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic [SH_W-1:0] shift,
    output logic            tick
);

    localparam int unsigned PRE_W = (1 << SH_W) - 1;

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] low_mask;

    // Bit i of the mask is set when the shift is larger than i.
    for (genvar i = 0; i < PRE_W; i++) begin : g_mask
        assign low_mask[i] = (32'(shift) > i);
    end

    assign tick = &(pre_cnt | ~low_mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pre_cnt <= '0;
        else if (restart) pre_cnt <= '0;
        else              pre_cnt <= pre_cnt + PRE_W'(1);
    end

endmodule

// File: rtl/lct_count_fsm.sv
`timescale 1ns/1ps
module lct_count_fsm
    import lct_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_evt,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             tick,
    input  entry_t           entry,
    output logic [CNT_W-1:0] live_count,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vector
);

    tmr_state_e       st_q, st_n;
    logic [CNT_W-1:0] cnt_n;
    logic             fire_n;
    logic [VEC_W-1:0] vec_n;

    always_comb begin
        st_n   = st_q;
        cnt_n  = live_count;
        fire_n = 1'b0;
        vec_n  = irq_vector;
        if (init_evt) begin
            st_n  = ST_IDLE;                    // INIT
            cnt_n = '0;
        end else if (load) begin
            if (load_val == '0) begin
                st_n  = ST_IDLE;                // ZERO
                cnt_n = '0;
            end else begin
                st_n  = ST_RUN;                 // LOAD
                cnt_n = load_val;
            end
        end else begin
            unique case (st_q)
                ST_IDLE, ST_DONE: ;
                ST_RUN: begin
                    if (tick) begin
                        if (live_count == '0) begin
                            fire_n = !entry.masked;
                            vec_n  = entry.vector;
                            if (entry.periodic) cnt_n = reload_val;   // RELOAD
                            else                st_n  = ST_DONE;      // FINISH
                        end else begin
                            cnt_n = live_count - CNT_W'(1);            // DEC
                        end
                    end
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            live_count <= '0;
        end else begin
            st_q       <= st_n;
            live_count <= cnt_n;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_valid  <= 1'b0;
            irq_vector <= '0;
        end else begin
            irq_valid  <= fire_n;
            irq_vector <= vec_n;
        end
    end

endmodule

// File: rtl/local_count_timer.sv
`timescale 1ns/1ps
module local_count_timer
    import lct_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_evt,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vector
);

    logic [CNT_W-1:0] start_val;
    logic [CFG_W-1:0] div_cfg;
    entry_t           entry;
    logic             load;
    logic             tick;
    logic [CNT_W-1:0] live_count;
    logic [CNT_W-1:0] entry_word;

    lct_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_evt (init_evt),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .start_val(start_val),
        .div_cfg  (div_cfg),
        .entry    (entry),
        .load     (load)
    );

    lct_prescaler #(.SH_W(SHIFT_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(load),
        .shift  (div_shift(div_cfg)),
        .tick   (tick)
    );

    lct_count_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_evt  (init_evt),
        .load      (load),
        .load_val  (wr_data),
        .reload_val(start_val),
        .tick      (tick),
        .entry     (entry),
        .live_count(live_count),
        .irq_valid (irq_valid),
        .irq_vector(irq_vector)
    );

    always_comb begin
        entry_word                = '0;
        entry_word[VEC_W-1:0]     = entry.vector;
        entry_word[MASK_POS]      = entry.masked;
        entry_word[MODE_POS]      = entry.periodic;
        unique case (rd_sel)
            SEL_START: rd_data = start_val;
            SEL_DIV:   rd_data = CNT_W'(div_cfg);
            SEL_ENTRY: rd_data = entry_word;
            SEL_LIVE:  rd_data = live_count;
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/lct_checker.sv
`timescale 1ns/1ps
module lct_checker
    import lct_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             init_evt,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic             irq_valid,
    input logic [VEC_W-1:0] irq_vector,
    input logic [CNT_W-1:0] live_count,
    input logic [CNT_W-1:0] start_val,
    input entry_t           entry
);

    logic start_wr;
    assign start_wr = wr_en && (wr_sel == SEL_START);

    // R8: a request lasts exactly one cycle
    a_r8_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |=> !irq_valid);

    // R8: a masked entry never produces a request
    a_r8_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !$past(entry.masked));

    // R8: the request carries the vector held at expiry
    a_r8_vector_match: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (irq_vector == $past(entry.vector)));

    // R6: in one-shot mode a zero count stays zero until the next start write
    a_r6_oneshot_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (live_count == '0 && !start_wr && !entry.periodic) |=> (live_count == '0));

    // R5: without a start write the count never rises, except a reload from zero
    a_r5_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !start_wr |=> (live_count <= $past(live_count) || $past(live_count) == '0));

    // R11: INIT clears count and start value and masks the entry
    a_r11_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        init_evt |=> (live_count == '0 && start_val == '0 && entry.masked && !irq_valid));

endmodule

bind local_count_timer lct_checker #(.CNT_W(CNT_W)) u_lct_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_evt  (init_evt),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .irq_valid (irq_valid),
    .irq_vector(irq_vector),
    .live_count(live_count),
    .start_val (start_val),
    .entry     (entry)
);

// File: tb/test_local_count_timer.sv
`timescale 1ns/1ps
module test_local_count_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_evt = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic        irq_valid;
    logic [7:0]  irq_vector;

    int cyc = 0;
    int n_chk = 0;
    int n_err = 0;
    int exp_vec[$];
    int exp_cyc[$];
    int c0;

    always #2 clk = ~clk;   // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    local_count_timer i_local_count_timer (
        .clk(clk), .rst_n(rst_n), .init_evt(init_evt),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .irq_valid(irq_valid), .irq_vector(irq_vector)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Called at a falling edge; returns at the next falling edge, just after the write edge
    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] sel, input logic [31:0] exp, input string tag);
        rd_sel = sel;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: start a run and push the expected request
    task automatic start_run(input int n, input int shift, input int vec, input bit expect_irq);
        wr(2'd0, n);
        c0 = cyc;
        if (expect_irq) begin
            exp_vec.push_back(vec);
            exp_cyc.push_back(c0 + ((n + 1) << shift));
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && irq_valid) begin
            if (exp_vec.size() == 0) begin
                chk("R6/R8/R9 unexpected request", 32'(irq_vector), 32'hFFFF_FFFF);
            end else begin
                chk("R8 request vector", 32'(irq_vector), 32'(exp_vec.pop_front()));
                chk("R3/R5/R7 request cycle", 32'(cyc), 32'(exp_cyc.pop_front()));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        rd_chk(2'd3, 32'h0, "R1 live count");
        rd_chk(2'd0, 32'h0, "R1 start value");
        rd_chk(2'd1, 32'h0, "R1 divider");
        rd_chk(2'd2, 32'h0001_0000, "R1 entry");
        chk("R1 irq_valid", 32'(irq_valid), 32'h0);

        // R2 divider keeps bits 0,1,3
        wr(2'd1, 32'hFFFF_FFFF);
        rd_chk(2'd1, 32'h0000_000B, "R2 divider mask");
        // R4 entry field layout
        wr(2'd2, 32'hFFFF_FFFF);
        rd_chk(2'd2, 32'h0003_00FF, "R4 entry fields");

        // R5/R6 one-shot divide by 1 (cfg 0xB -> code 7 -> shift 0)
        wr(2'd1, 32'hB);
        wr(2'd2, 32'h0000_0041);
        start_run(5, 0, 8'h41, 1'b1);
        rd_chk(2'd3, 32'd5, "R5 count after load");
        idle(3);
        rd_chk(2'd3, 32'd2, "R5 count after 3 ticks");
        idle(45);
        rd_chk(2'd3, 32'd0, "R6 count stays zero");

        // R3 divide by 2 (cfg 0 -> shift 1)
        wr(2'd1, 32'h0);
        start_run(3, 1, 8'h41, 1'b1);
        idle(4);
        rd_chk(2'd3, 32'd1, "R3 divide by 2 count");
        idle(10);
        // R3 cfg 0x2 -> code 2 -> shift 3
        wr(2'd1, 32'h2);
        start_run(2, 3, 8'h41, 1'b1);
        idle(30);
        // R3 cfg 0x8 -> code 4 -> shift 5 (bit 3 lands in code bit 2)
        wr(2'd1, 32'h8);
        start_run(1, 5, 8'h41, 1'b1);
        idle(70);
        // R3 cfg 0x3 -> code 3 -> shift 4
        wr(2'd1, 32'h3);
        start_run(2, 4, 8'h41, 1'b1);
        idle(60);
        rd_chk(2'd3, 32'd0, "R3 count zero after run");

        // R7 periodic, period N+1
        wr(2'd1, 32'hB);
        wr(2'd2, 32'h0002_0077);
        start_run(4, 0, 8'h77, 1'b1);
        exp_vec.push_back(8'h77); exp_cyc.push_back(c0 + 10);
        exp_vec.push_back(8'h77); exp_cyc.push_back(c0 + 15);
        idle(6);
        rd_chk(2'd3, 32'd3, "R7 count after reload");
        idle(10);
        // R9 writing zero stops the periodic timer
        wr(2'd0, 32'h0);
        idle(30);
        rd_chk(2'd3, 32'd0, "R9 periodic stopped");

        // R9 zero start in one-shot
        wr(2'd2, 32'h0000_0012);
        start_run(0, 0, 8'h12, 1'b0);
        idle(20);
        rd_chk(2'd3, 32'd0, "R9 zero start count");

        // R8 masked entry: count runs, nothing raised
        wr(2'd2, 32'h0001_0033);
        start_run(3, 0, 8'h33, 1'b0);
        idle(2);
        rd_chk(2'd3, 32'd1, "R8 masked count runs");
        idle(20);

        // R10 entry change keeps the count
        wr(2'd2, 32'h0000_0022);
        start_run(10, 0, 8'h33, 1'b1);
        idle(3);
        wr(2'd2, 32'h0000_0033);
        rd_chk(2'd3, 32'd6, "R10 count not restarted");
        idle(20);
        // R10 masking before expiry suppresses the request
        wr(2'd2, 32'h0000_0044);
        start_run(6, 0, 8'h44, 1'b0);
        idle(2);
        wr(2'd2, 32'h0001_0044);
        idle(20);
        rd_chk(2'd3, 32'd0, "R10 masked before expiry");

        // R11 INIT
        wr(2'd2, 32'h0000_0055);
        start_run(20, 0, 8'h55, 1'b0);
        idle(5);
        init_evt = 1'b1;
        idle(1);
        init_evt = 1'b0;
        rd_chk(2'd3, 32'd0, "R11 live count");
        rd_chk(2'd0, 32'd0, "R11 start value");
        rd_chk(2'd2, 32'h0001_0000, "R11 entry");
        idle(40);

        chk("R6 all expected requests seen", 32'(exp_vec.size()), 32'd0);
        report();
    end

endmodule